// File: doc/BRIEF.md
# Hardware Page Table Walker

This block turns a virtual address into a physical address by reading the in-memory paging structures one entry at a time through a 64-bit read port. A single state machine handles three translation layouts. The first is a two-level layout with 4-byte entries. The second is a three-level layout with 8-byte entries. The third is a long layout of four or five levels with 8-byte entries. Large pages end a walk early at several depths. With translation off, the block passes the address through.

A client presents one request together with the table base and the mode flags. The walker then issues dependent reads, one at a time, and ends with a single completion pulse. The pulse carries either a physical address and a page-size code, or a fault flag. Every entry address is masked with the supplied A20 mask before it leaves the block.

Top module: `page_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each request produces exactly one single-cycle `walk_done` pulse, and `req_ready` is high again in the cycle after that pulse.
- R2: With `req_paging` low, the result is `req_va` ANDed with `req_a20`, with size code 0 (4 KiB) and no fault. No memory read is issued.
- R3: With `req_long` high, bits 63 down to 47 must all be equal. With `req_five` also high, only bits 63 down to 56 must be equal. If they are not, the walk faults and issues no memory read.
- R4: In long mode the walk starts at level 4 (five-level) or level 3. At level L, the entry address is the current base plus 8 times the 9-bit field of `req_va` that starts at bit 12+9L. The first base is `req_tbl_base` with bits 11:0 cleared. Each later base is bits PA_W-1:12 of the fetched entry.
- R5: Bit 0 of each fetched entry is its present bit. If it is clear, the walk ends with `walk_fault` high and no further reads.
- R6: Bit 7 of an entry is the page-size flag. When set at level 1 in long or three-level mode, the entry is a 2 MiB leaf (size code 1). When set at level 2 in long mode, it is a 1 GiB leaf (size code 3). It is ignored at higher levels.
- R7: In three-level mode (`req_ext` high, `req_long` low), the first entry is read at (`req_tbl_base` with bits 4:0 cleared) plus 8 times `req_va[31:30]`. Levels 1 and 0 then follow as in R4.
- R8: In two-level mode (`req_ext` and `req_long` low), only the low 32 bits of each returned word are used. The directory entry is read at (`req_tbl_base` with bits 11:0 cleared) plus 4 times `req_va[31:22]`. The table entry is read at the directory entry's bits 31:12 (as a 4 KiB-aligned base) plus 4 times `req_va[21:12]`.
- R9: In two-level mode, a directory entry with bit 7 set while `req_pse` is high is a 4 MiB leaf (size code 2). Its bits 31:22 give physical bits 31:22, and its bits 20:13 give physical bits 39:32. With `req_pse` low, bit 7 is ignored and the table is read.
- R10: Every issued `mem_req_addr` equals the computed entry address ANDed with `req_a20`.
- R11: A leaf's physical address is its frame with the bits below the page size cleared, ORed with the same low bits of `req_va`.
- R12: A read is held, with a stable address, until `mem_req_ready` is high. At most one read is outstanding. No new read is issued until `mem_rsp_valid` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request may be taken |
| req_va | input | 64 | Virtual address to translate |
| req_tbl_base | input | PA_W | Top-level table base |
| req_paging | input | 1 | Translation enabled |
| req_ext | input | 1 | Use 8-byte entries (three-level layout when not long) |
| req_long | input | 1 | Long layout |
| req_five | input | 1 | Five-level long layout |
| req_pse | input | 1 | Allow 4 MiB pages in two-level layout |
| req_a20 | input | PA_W | Mask applied to entry addresses and flat output |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry word |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Walk faulted (valid with walk_done) |
| walk_pa | output | PA_W | Physical address (valid with walk_done) |
| walk_size | output | 2 | Page size code: 0 4K, 1 2M, 2 4M, 3 1G |

## Verification
The directed cases pin down one mechanism each. Flat mode with A20 bit 20 cleared shows the pass-through mask. Addresses that are non-canonical for four levels but canonical for five show the two check widths apart. A two-level directory entry with bit 7 set, tried with and without `req_pse`, separates a 4 MiB leaf from a table descent. Hand-built 1 GiB and 2 MiB leaves, with stray high entry bits, show the frame masking and offset merge. A randomly seeded stream then mixes all modes, A20 settings, random ready stalls and lazily built tables with missing and large entries. The read count per request tells early termination apart from full descents, and every issued address is checked against the A20 mask.

// File: rtl/pw_pkg.sv
// Shared types for the page table walker.
// Assumes a 64-bit virtual address and 64-bit entry words on the read port.
package pw_pkg;
    localparam int VA_W    = 64;
    localparam int ENTRY_W = 64;
    localparam int LVL_W   = 3;
    localparam int IDX_W   = 9;
    localparam int PAGE_SH = 12;

    typedef enum logic [1:0] {
        PM_FLAT = 2'd0,
        PM_W32  = 2'd1,
        PM_X3   = 2'd2,
        PM_LONG = 2'd3
    } pw_mode_e;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0,
        SZ_2M = 2'd1,
        SZ_4M = 2'd2,
        SZ_1G = 2'd3
    } pw_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } pw_state_e;
endpackage

// File: rtl/pw_entry_addr.sv
// Entry address generator: forms the byte address of the entry for the
// current level from the table base and the virtual address, then applies
// the A20 mask. Purely combinational. Assumes base is already aligned.
module pw_entry_addr
    import pw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  pw_mode_e             mode,
    input  logic [LVL_W-1:0]     lvl,
    input  logic [PA_W-1:0]      base,
    input  logic [VA_W-1:0]      va,
    input  logic [PA_W-1:0]      a20,
    output logic [PA_W-1:0]      addr
);
    localparam logic [VA_W-1:0] IDX_MASK = VA_W'((1 << IDX_W) - 1);

    logic [PA_W-1:0] off;
    int unsigned     sh;

    // Select the index field and entry scale for the mode and level.
    always_comb begin
        sh  = PAGE_SH + IDX_W * int'(lvl);
        off = '0;
        if (mode == PM_W32) begin
            off = (lvl != '0) ? PA_W'({va[31:22], 2'b00})
                              : PA_W'({va[21:12], 2'b00});
        end else if (mode == PM_X3 && lvl == LVL_W'(2)) begin
            off = PA_W'({va[31:30], 3'b000});
        end else begin
            off = PA_W'((va >> sh) & IDX_MASK) << 3;
        end
        addr = (base + off) & a20;
    end
endmodule

// File: rtl/pw_entry_decode.sv
// Entry decoder: interprets a fetched entry for the current mode and level,
// flags present and leaf, and builds the next table base or the final
// physical address. Purely combinational. Page-size flag is bit 7.
module pw_entry_decode
    import pw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  pw_mode_e             mode,
    input  logic [LVL_W-1:0]     lvl,
    input  logic [ENTRY_W-1:0]   entry,
    input  logic [VA_W-1:0]      va,
    input  logic                 pse,
    output logic                 present,
    output logic                 leaf,
    output pw_size_e             size,
    output logic [PA_W-1:0]      next_base,
    output logic [PA_W-1:0]      pa
);
    logic [31:0]     e32;
    logic [PA_W-1:0] frame;
    logic [PA_W-1:0] mask;
    logic            ps;

    // Decide leaf/size and frame, then merge the page offset.
    always_comb begin
        e32     = entry[31:0];
        ps      = entry[7];
        present = entry[0];
        leaf    = 1'b0;
        size    = SZ_4K;
        if (mode == PM_W32) begin
            frame = PA_W'({e32[31:12], 12'h000});
            if (lvl == '0) begin
                leaf = 1'b1;
            end else if (ps && pse) begin
                leaf  = 1'b1;
                size  = SZ_4M;
                frame = PA_W'({e32[20:13], e32[31:22], 22'h0});
            end
        end else begin
            frame = {entry[PA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
            if (lvl == '0) begin
                leaf = 1'b1;
            end else if (lvl == LVL_W'(1) && ps) begin
                leaf = 1'b1;
                size = SZ_2M;
            end else if (lvl == LVL_W'(2) && ps && mode == PM_LONG) begin
                leaf = 1'b1;
                size = SZ_1G;
            end
        end
        case (size)
            SZ_2M:   mask = PA_W'(32'h001f_ffff);
            SZ_4M:   mask = PA_W'(32'h003f_ffff);
            SZ_1G:   mask = PA_W'(32'h3fff_ffff);
            default: mask = PA_W'(32'h0000_0fff);
        endcase
        next_base = frame;
        pa        = (frame & ~mask) | (va[PA_W-1:0] & mask);
    end
endmodule

// File: rtl/page_walker.sv
// Page table walker top: takes one translation request while idle, resolves
// flat and non-canonical cases at once, otherwise walks the tables with one
// outstanding 64-bit read at a time, and pulses walk_done with the result.
// Assumes the memory returns exactly one mem_rsp_valid per accepted read.
module page_walker
    import pw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_va,
    input  logic [PA_W-1:0]      req_tbl_base,
    input  logic                 req_paging,
    input  logic                 req_ext,
    input  logic                 req_long,
    input  logic                 req_five,
    input  logic                 req_pse,
    input  logic [PA_W-1:0]      req_a20,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PA_W-1:0]      mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [ENTRY_W-1:0]   mem_rsp_data,
    output logic                 walk_done,
    output logic                 walk_fault,
    output logic [PA_W-1:0]      walk_pa,
    output logic [1:0]           walk_size
);
    localparam logic [PA_W-1:0] ALIGN_4K  = ~PA_W'(32'hfff);
    localparam logic [PA_W-1:0] ALIGN_32B = ~PA_W'(32'h1f);

    pw_state_e        st;
    pw_mode_e         mode_q, mode_in;
    logic [LVL_W-1:0] lvl_q, lvl_in;
    logic [PA_W-1:0]  base_q, base_in;
    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  a20_q;
    logic             pse_q;
    logic             canon_ok;

    logic             d_present, d_leaf;
    pw_size_e         d_size;
    logic [PA_W-1:0]  d_next, d_pa;

    // Classify an incoming request: mode, start level, start base, canonicity.
    always_comb begin
        if (!req_paging)   mode_in = PM_FLAT;
        else if (req_long) mode_in = PM_LONG;
        else if (req_ext)  mode_in = PM_X3;
        else               mode_in = PM_W32;
        case (mode_in)
            PM_LONG: lvl_in = req_five ? LVL_W'(4) : LVL_W'(3);
            PM_X3:   lvl_in = LVL_W'(2);
            default: lvl_in = LVL_W'(1);
        endcase
        base_in = req_tbl_base & ((mode_in == PM_X3) ? ALIGN_32B : ALIGN_4K);
        if (req_five) canon_ok = (&req_va[63:56]) || !(|req_va[63:56]);
        else          canon_ok = (&req_va[63:47]) || !(|req_va[63:47]);
    end

    pw_entry_addr #(.PA_W(PA_W)) u_addr (
        .mode (mode_q),
        .lvl  (lvl_q),
        .base (base_q),
        .va   (va_q),
        .a20  (a20_q),
        .addr (mem_req_addr)
    );

    pw_entry_decode #(.PA_W(PA_W)) u_dec (
        .mode      (mode_q),
        .lvl       (lvl_q),
        .entry     (mem_rsp_data),
        .va        (va_q),
        .pse       (pse_q),
        .present   (d_present),
        .leaf      (d_leaf),
        .size      (d_size),
        .next_base (d_next),
        .pa        (d_pa)
    );

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            mode_q     <= PM_FLAT;
            lvl_q      <= '0;
            base_q     <= '0;
            va_q       <= '0;
            a20_q      <= '0;
            pse_q      <= 1'b0;
            walk_fault <= 1'b0;
            walk_pa    <= '0;
            walk_size  <= SZ_4K;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        mode_q     <= mode_in;
                        lvl_q      <= lvl_in;
                        base_q     <= base_in;
                        va_q       <= req_va;
                        a20_q      <= req_a20;
                        pse_q      <= req_pse;
                        walk_fault <= 1'b0;
                        walk_pa    <= '0;
                        walk_size  <= SZ_4K;
                        if (mode_in == PM_FLAT) begin
                            walk_pa <= req_va[PA_W-1:0] & req_a20;
                            st      <= ST_DONE;
                        end else if (mode_in == PM_LONG && !canon_ok) begin
                            walk_fault <= 1'b1;
                            st         <= ST_DONE;
                        end else begin
                            st <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) st <= ST_RSP;
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        if (!d_present) begin
                            walk_fault <= 1'b1;
                            st         <= ST_DONE;
                        end else if (d_leaf) begin
                            walk_pa   <= d_pa;
                            walk_size <= d_size;
                            st        <= ST_DONE;
                        end else begin
                            base_q <= d_next;
                            lvl_q  <= lvl_q - LVL_W'(1);
                            st     <= ST_REQ;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs decoded from the state.
    always_comb begin
        req_ready     = (st == ST_IDLE);
        mem_req_valid = (st == ST_REQ);
        walk_done     = (st == ST_DONE);
    end
endmodule

// File: rtl/pw_checker.sv
// Protocol and ordering checker for page_walker, attached by bind.
// Keeps its own copy of the accepted request's A20 mask and no-read class.
module pw_checker
    import pw_pkg::*;
#(
    parameter int PA_W = 52
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_va,
    input logic               req_paging,
    input logic               req_long,
    input logic               req_five,
    input logic [PA_W-1:0]    req_a20,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [PA_W-1:0]    mem_req_addr,
    input logic               mem_rsp_valid,
    input logic               walk_done,
    input logic               walk_fault
);
    logic [PA_W-1:0] a20_c;
    logic            flat_c, bad_c, outst_c, canon_in;

    // Canonical form of the incoming address, judged at the port.
    always_comb begin
        canon_in = req_five ? ((&req_va[63:56]) || !(|req_va[63:56]))
                            : ((&req_va[63:47]) || !(|req_va[63:47]));
    end

    // Track the accepted request's class and the outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a20_c   <= '0;
            flat_c  <= 1'b0;
            bad_c   <= 1'b0;
            outst_c <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                a20_c  <= req_a20;
                flat_c <= !req_paging;
                bad_c  <= req_paging && req_long && !canon_in;
            end
            if (mem_req_valid && mem_req_ready) outst_c <= 1'b1;
            else if (mem_rsp_valid)             outst_c <= 1'b0;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> (!walk_done && req_ready)); // R1
    AST_FLAT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !flat_c); // R2
    AST_FLAT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && flat_c) |-> !walk_fault); // R2
    AST_NONCANON_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !bad_c); // R3
    AST_NONCANON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && bad_c) |-> walk_fault); // R3
    AST_A20_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_addr & ~a20_c) == '0)); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R12
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outst_c |-> !mem_req_valid); // R12
endmodule

bind page_walker pw_checker #(.PA_W(PA_W)) u_chk (.*);

// File: tb/page_walker_tb.sv
// Self-checking bench: directed corners plus seeded random walks over a
// sparse table memory, compared with a reference walk computed here.
module page_walker_tb;
    localparam int PA_W = 52;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [63:0]       req_va = '0;
    logic [PA_W-1:0]   req_tbl_base = '0;
    logic              req_paging = 1'b0, req_ext = 1'b0, req_long = 1'b0;
    logic              req_five = 1'b0, req_pse = 1'b0;
    logic [PA_W-1:0]   req_a20 = '1;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [PA_W-1:0]   mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [63:0]       mem_rsp_data = '0;
    logic              walk_done, walk_fault;
    logic [PA_W-1:0]   walk_pa;
    logic [1:0]        walk_size;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [63:0] mem [logic [PA_W-1:0]];
    int          n_reads;
    int          proto_bad;
    int          a20_bad;
    logic [PA_W-1:0] cur_a20 = '1;

    page_walker #(.PA_W(PA_W)) u_dut (.*);

    always #2.5 clk = ~clk;

    // Watchdog: a hung run is a failure but still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] get_entry(input logic [PA_W-1:0] a, input bit build);
        logic [63:0] e;
        int unsigned r;
        if (!mem.exists(a)) begin
            if (!build) return 64'h0;
            e = {$urandom, $urandom};
            r = $urandom;
            e[0] = (r % 8) != 0;
            e[7] = ((r >> 3) % 4) == 0;
            mem[a] = e;
        end
        return mem[a];
    endfunction

    // Reference walk written from the requirements; builds missing entries.
    function automatic void ref_walk(input logic [63:0] va, input logic [PA_W-1:0] tb,
                                     input bit pg, input bit ext, input bit lm, input bit five,
                                     input bit pse, input logic [PA_W-1:0] a20,
                                     output logic [PA_W-1:0] pa, output logic [1:0] sz,
                                     output bit flt, output int nrd);
        logic [PA_W-1:0] base, a, mask, frame;
        logic [63:0] e;
        int top;
        bit leaf;
        pa = '0; sz = 2'd0; flt = 1'b0; nrd = 0;
        if (!pg) begin pa = va[PA_W-1:0] & a20; return; end
        if (!lm && !ext) begin
            a = ((tb & ~PA_W'(32'hfff)) + PA_W'(va[31:22]) * 4) & a20;
            e = get_entry(a, 1'b1); nrd++;
            if (!e[0]) begin flt = 1'b1; return; end
            if (e[7] && pse) begin
                sz = 2'd2;
                pa = PA_W'({e[20:13], e[31:22], 22'h0}) | PA_W'(va[21:0]);
                return;
            end
            a = (PA_W'({e[31:12], 12'h0}) + PA_W'(va[21:12]) * 4) & a20;
            e = get_entry(a, 1'b1); nrd++;
            if (!e[0]) begin flt = 1'b1; return; end
            pa = PA_W'({e[31:12], va[11:0]});
            return;
        end
        if (lm) begin
            if (five ? !(va[63:56] == 8'h00 || va[63:56] == 8'hff)
                     : !(va[63:47] == 17'h0 || va[63:47] == 17'h1ffff)) begin
                flt = 1'b1; return;
            end
            top = five ? 4 : 3;
            base = tb & ~PA_W'(32'hfff);
        end else begin
            top = 2;
            base = tb & ~PA_W'(32'h1f);
        end
        for (int l = top; l >= 0; l--) begin
            if (!lm && l == 2) a = base + PA_W'(va[31:30]) * 8;
            else               a = base + PA_W'((va >> (12 + 9 * l)) & 64'h1ff) * 8;
            a = a & a20;
            e = get_entry(a, 1'b1); nrd++;
            if (!e[0]) begin flt = 1'b1; return; end
            leaf = 1'b0; mask = PA_W'(32'hfff);
            if (l == 0) begin leaf = 1'b1; sz = 2'd0; end
            else if (l == 1 && e[7]) begin leaf = 1'b1; sz = 2'd1; mask = PA_W'(32'h1fffff); end
            else if (l == 2 && lm && e[7]) begin leaf = 1'b1; sz = 2'd3; mask = PA_W'(32'h3fffffff); end
            frame = {e[PA_W-1:12], 12'h0};
            if (leaf) begin pa = (frame & ~mask) | (va[PA_W-1:0] & mask); return; end
            base = frame;
        end
    endfunction

    // Memory responder: random ready stalls, one-cycle response per read.
    initial begin
        bit pend = 1'b0;
        bit held = 1'b0;
        logic [PA_W-1:0] paddr = '0;
        logic [PA_W-1:0] haddr = '0;
        forever begin
            @(negedge clk);
            if (pend && mem_req_valid) proto_bad++;
            if (held && !(mem_req_valid && mem_req_addr == haddr)) proto_bad++;
            mem_rsp_valid = pend;
            if (pend) mem_rsp_data = get_entry(paddr, 1'b0);
            pend = 1'b0;
            mem_req_ready = ($urandom % 3) != 0;
            held = 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                n_reads++;
                paddr = mem_req_addr;
                if ((mem_req_addr & ~cur_a20) != '0) a20_bad++;
                pend = 1'b1;
            end else if (mem_req_valid) begin
                held = 1'b1;
                haddr = mem_req_addr;
            end
        end
    end

    task automatic run_case(input string tag, input logic [63:0] va, input logic [PA_W-1:0] tb,
                            input bit pg, input bit ext, input bit lm, input bit five,
                            input bit pse, input logic [PA_W-1:0] a20,
                            input bit has_lit, input logic [PA_W-1:0] lit_pa, input logic [1:0] lit_sz);
        logic [PA_W-1:0] e_pa;
        logic [1:0] e_sz;
        bit e_flt;
        int e_nrd;
        int k;
        ref_walk(va, tb, pg, ext, lm, five, pse, a20, e_pa, e_sz, e_flt, e_nrd);
        @(negedge clk);
        n_reads = 0; a20_bad = 0; proto_bad = 0; cur_a20 = a20;
        req_va = va; req_tbl_base = tb; req_paging = pg; req_ext = ext;
        req_long = lm; req_five = five; req_pse = pse; req_a20 = a20;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R1 busy after accept"}, req_ready == 1'b0, req_ready, 0);
        k = 0;
        while (!walk_done && k < 400) begin @(negedge clk); k++; end
        check({tag, " R1 done seen"}, walk_done == 1'b1, walk_done, 1);
        check({tag, " R5 fault"}, walk_fault == e_flt, walk_fault, e_flt);
        if (!e_flt) begin
            check({tag, " R11 pa"}, walk_pa == e_pa, walk_pa, e_pa);
            check({tag, " R6 size"}, walk_size == e_sz, walk_size, e_sz);
        end
        if (has_lit) begin
            check({tag, " literal pa"}, walk_pa == lit_pa, walk_pa, lit_pa);
            check({tag, " literal size"}, walk_size == lit_sz, walk_size, lit_sz);
        end
        check({tag, " R4 read count"}, n_reads == e_nrd, n_reads, e_nrd);
        check({tag, " R10 a20 on reads"}, a20_bad == 0, a20_bad, 0);
        check({tag, " R12 read protocol"}, proto_bad == 0, proto_bad, 0);
        @(negedge clk);
        check({tag, " R1 single pulse"}, walk_done == 1'b0 && req_ready == 1'b1,
              {walk_done, req_ready}, 2'b01);
    endtask

    initial begin
        logic [63:0] va;
        bit lm, ext, five;
        int unsigned r;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready", req_ready == 1'b1, req_ready, 1);
        check("R1 reset done", walk_done == 1'b0, walk_done, 0);
        check("R12 reset no read", mem_req_valid == 1'b0, mem_req_valid, 0);

        // R2: flat pass-through with A20 bit 20 cleared.
        mem.delete();
        run_case("R2 flat a20", 64'h0000_0000_0012_3456, '0, 0, 0, 0, 0, 0,
                 ~PA_W'(32'h0010_0000), 1, PA_W'(32'h0002_3456), 2'd0);
        // R3: non-canonical for four levels, canonical for five.
        mem.delete();
        run_case("R3 noncanon 4lvl", 64'h0000_8000_0000_0000, PA_W'(32'h4000), 1, 0, 1, 0, 0, '1, 0, '0, 0);
        mem.delete();
        run_case("R3 canon 5lvl", 64'h0000_8000_0000_0000, PA_W'(32'h4000), 1, 0, 1, 1, 0, '1, 0, '0, 0);
        mem.delete();
        run_case("R3 noncanon 5lvl", 64'h0100_0000_0000_0000, PA_W'(32'h4000), 1, 0, 1, 1, 0, '1, 0, '0, 0);
        // R9: two-level 4 MiB leaf, then the same entry with the extension off.
        mem.delete();
        mem[PA_W'(32'h1804)] = 64'h0000_0000_FFD5_6081;
        run_case("R9 R8 4M leaf", 64'h0000_0000_8040_1234, PA_W'(32'h1000), 1, 0, 0, 0, 1, '1,
                 1, PA_W'(40'hAB_FFC0_1234), 2'd2);
        mem.delete();
        mem[PA_W'(32'h1804)] = 64'h0000_0000_FFD5_6081;
        run_case("R9 R8 pse off descends", 64'h0000_0000_8040_1234, PA_W'(32'h1000), 1, 0, 0, 0, 0, '1, 0, '0, 0);
        // R5: top-level entry not present.
        mem.delete();
        mem[PA_W'(32'h5000)] = 64'hFFFF_FFFF_FFFF_FFFE;
        run_case("R5 not present", 64'h0, PA_W'(32'h5000), 1, 0, 1, 0, 0, '1, 0, '0, 0);
        // R6: 1 GiB leaf with a stray top bit in the pointer entry.
        mem.delete();
        mem[PA_W'(32'h3000)] = 64'h8000_0000_0000_7003;
        mem[PA_W'(32'h7008)] = 64'h0000_000A_C000_0083;
        run_case("R6 R11 1G leaf", 64'h0000_0000_4000_1234, PA_W'(32'h3000), 1, 0, 1, 0, 0, '1,
                 1, PA_W'(40'h0A_C000_1234), 2'd3);
        // R7: three-level layout ending in a 2 MiB leaf.
        mem.delete();
        mem[PA_W'(32'h9038)] = 64'h0000_0000_0000_B001;
        mem[PA_W'(32'hB008)] = 64'h0000_0012_3460_0081;
        run_case("R7 R6 2M leaf", 64'h0000_0000_C020_0ABC, PA_W'(32'h903F), 1, 1, 0, 0, 0, '1,
                 1, PA_W'(40'h12_3460_0ABC), 2'd1);

        // Seeded random walks over all modes.
        for (int i = 0; i < 300; i++) begin
            mem.delete();
            r = $urandom;
            lm = (r % 3) == 0;
            ext = (r % 3) == 1;
            five = ((r >> 4) & 1) != 0;
            va = {$urandom, $urandom};
            if (lm && ((r >> 5) % 8) != 0) begin
                if (five) va[63:57] = {7{va[56]}};
                else      va[63:48] = {16{va[47]}};
            end
            run_case("R4 R6 R8 R10 R11 random", va, PA_W'({$urandom, $urandom}),
                     ((r >> 8) % 8) != 0, ext, lm, five, ((r >> 11) & 1) != 0,
                     (((r >> 12) % 4) == 0) ? ~PA_W'(32'h0010_0000) : '1, 0, '0, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule